// File: doc/BRIEF.md
# Receive Descriptor and Status Ring Engine

This block is the receive-side queue manager of a network MAC. Free receive buffers are described by a ring of two-word descriptors in memory, and each finished frame is reported through a second ring of two-word status entries. For every incoming frame the engine reads the descriptor at the current descriptor slot and counts the frame's beats from a beat-level stream. It checks the length against fixed limits and against the buffer size. It then writes the status pair into the current status slot and raises a level receive interrupt.

Software gives slots back through two separate enqueue inputs, one for descriptors and one for status slots. Each enqueue adds a count to its own credit counter. A frame is placed only when both counters are non-zero. Otherwise the frame is taken from the stream and discarded, and the loss is flagged on the next frame that is placed. Payload bytes are written by a separate data path, so the stream here carries only frame boundaries and per-frame error flags.

The incoming stream uses valid/ready. A beat is taken on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is low while the engine is idle, while it fetches a descriptor and while it writes status. The source must then hold the beat and its flags unchanged. Memory is a simple synchronous port: a read issued in one cycle returns `mem_rdata` on the next cycle, and a write completes in the cycle it is issued.

Top module: `rx_ring_engine`

## Requirements
- R1: For each placed frame, the engine reads descriptor word 1 at the current descriptor address plus 4. Bits 30:16 of that word give the buffer index and bits 15:0 give the buffer length in bytes.
- R2: Status word 1 is written at the current status address plus 4. Bit 31 is 1, bits 30:16 hold the buffer index from the descriptor, and bits 15:0 hold the number of beats in the frame.
- R3: Status word 0 is written at the current status address. Bits 31, 29 and 28 are 1. Bit 30 is 1 only when no error is present. Bit 21 is the OR of the framing (bit 19), runt (bit 18), extra-data (bit 17) and CRC (bit 16) flags. Bit 15 copies `crc_in_len`. All other bits are 0.
- R4: The runt flag is set when the length is below MIN_LEN. The extra-data flag is set when the length exceeds MAX_LEN or exceeds the descriptor's buffer length. The framing and CRC flags copy `in_frame_err` and `in_crc_err` on the last beat.
- R5: Status word 1 is written in the cycle before status word 0, so the processed flag in word 0 never appears ahead of the length.
- R6: Both credit counters reset to ENTRIES. An enqueue adds its count, and the result saturates at ENTRIES. Each placed frame consumes one credit from each counter.
- R7: A frame that arrives while either credit is zero is still fully accepted from the stream. It causes no memory write and does not raise the interrupt.
- R8: After one or more dropped frames, bit 20 of word 0 is set on the next placed frame. It is clear on the frames placed after that one.
- R9: The descriptor and status current addresses equal their base plus 8 times the slot. Each address advances by 8 per placed frame and wraps to its base after slot ENTRIES-1. A `ring_init` pulse resets both slots and both credits.
- R10: `rx_irq` rises in the cycle after status word 0 is written. It stays high until an `irq_clr` pulse.
- R11: `in_ready` is low while no frame is in progress. A beat held across stalls or valid gaps is taken exactly once.
- R12: After reset, `in_ready`, `mem_req` and `rx_irq` are low, and both current addresses equal their bases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_init | input | 1 | Restart both rings at slot 0 with full credit |
| desc_base | input | 32 | Byte base address of the descriptor ring |
| stat_base | input | 32 | Byte base address of the status ring |
| desc_enq_en | input | 1 | Add `desc_enq_cnt` descriptor credits |
| desc_enq_cnt | input | ENQ_W | Number of descriptors returned |
| stat_enq_en | input | 1 | Add `stat_enq_cnt` status credits |
| stat_enq_cnt | input | ENQ_W | Number of status slots returned |
| crc_in_len | input | 1 | Received length includes the CRC bytes |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Stream beat accepted |
| in_last | input | 1 | Final beat of the frame |
| in_frame_err | input | 1 | Framing error, sampled with the last beat |
| in_crc_err | input | 1 | CRC error, sampled with the last beat |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |
| rx_irq | output | 1 | Receive interrupt, level |
| irq_clr | input | 1 | Clear the receive interrupt |
| desc_cur_addr | output | 32 | Current descriptor address |
| stat_cur_addr | output | 32 | Current status address |

## Verification
Every frame length from 1 to 44 beats is sent through a four-slot ring. Framing and CRC errors are mixed in, and the CRC-in-length setting is toggled. This separates the runt, in-range and over-maximum length bands. One slot has a small buffer, so an over-buffer frame is told apart from an over-maximum frame. Some frames have valid gaps between beats, which tests that each held beat is taken exactly once.

A second phase stops returning credit and then returns only descriptors. This shows that either empty counter drops the frame, and that the overrun flag lands on the next placed frame only. Over-large enqueue counts show saturation, because exactly ENTRIES frames land before the next drop. A final ring restart at a new status base confirms the address reload.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LATCH, ST_RECV, ST_DROP, ST_WR1, ST_WR0
  } rxr_state_e;

  localparam int BIT_DONE  = 31;
  localparam int BIT_OK    = 30;
  localparam int BIT_EOF   = 29;
  localparam int BIT_EOB   = 28;
  localparam int BIT_ANY   = 21;
  localparam int BIT_OVR   = 20;
  localparam int BIT_FRM   = 19;
  localparam int BIT_RUNT  = 18;
  localparam int BIT_XTRA  = 17;
  localparam int BIT_CRC   = 16;
  localparam int BIT_CRCIN = 15;
endpackage

// File: rtl/rxr_credit.sv
module rxr_credit #(
  parameter int ENTRIES = 64,
  parameter int ENQ_W   = 8,
  parameter int CW      = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             add_en,
  input  logic [ENQ_W-1:0] add_cnt,
  input  logic             take,
  output logic             avail,
  output logic [CW-1:0]    level
);
  localparam int SW = ((CW > ENQ_W) ? CW : ENQ_W) + 2;

  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(level) + (add_en ? SW'(add_cnt) : SW'(0)) - SW'(take);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || reload)          level <= CW'(ENTRIES);
    else if (sum > SW'(ENTRIES))   level <= CW'(ENTRIES);
    else                           level <= sum[CW-1:0];
  end

  assign avail = (level != '0);
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int ENTRIES = 64,
  parameter int IW      = $clog2(ENTRIES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reload,
  input  logic        step,
  input  logic [31:0] base,
  output logic [31:0] cur_addr
);
  logic [IW-1:0] slot;

  always_ff @(posedge clk) begin
    if (!rst_n || reload)                 slot <= '0;
    else if (step) begin
      if (slot == IW'(ENTRIES - 1))       slot <= '0;
      else                                slot <= slot + 1'b1;
    end
  end

  assign cur_addr = base + (32'(slot) << 3);
endmodule

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt
  import rxr_pkg::*;
#(
  parameter int MAX_LEN = 2044,
  parameter int MIN_LEN = 60
) (
  input  logic [15:0] beats,
  input  logic [14:0] buf_idx,
  input  logic [15:0] buf_len,
  input  logic        frm_err,
  input  logic        crc_err,
  input  logic        crc_incl,
  input  logic        ovr,
  output logic [31:0] word0,
  output logic [31:0] word1
);
  logic runt, xtra, any_err;

  always_comb begin
    runt    = 32'(beats) < MIN_LEN;
    xtra    = (32'(beats) > MAX_LEN) || (beats > buf_len);
    any_err = frm_err | crc_err | runt | xtra;

    word1          = '0;
    word1[31]      = 1'b1;
    word1[30:16]   = buf_idx;
    word1[15:0]    = beats;

    word0            = '0;
    word0[BIT_DONE]  = 1'b1;
    word0[BIT_OK]    = ~any_err;
    word0[BIT_EOF]   = 1'b1;
    word0[BIT_EOB]   = 1'b1;
    word0[BIT_ANY]   = any_err;
    word0[BIT_OVR]   = ovr;
    word0[BIT_FRM]   = frm_err;
    word0[BIT_RUNT]  = runt;
    word0[BIT_XTRA]  = xtra;
    word0[BIT_CRC]   = crc_err;
    word0[BIT_CRCIN] = crc_incl;
  end
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rxr_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int MAX_LEN = 2044,
  parameter int MIN_LEN = 60,
  parameter int ENQ_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_init,
  input  logic [31:0]      desc_base,
  input  logic [31:0]      stat_base,
  input  logic             desc_enq_en,
  input  logic [ENQ_W-1:0] desc_enq_cnt,
  input  logic             stat_enq_en,
  input  logic [ENQ_W-1:0] stat_enq_cnt,
  input  logic             crc_in_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_last,
  input  logic             in_frame_err,
  input  logic             in_crc_err,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             rx_irq,
  input  logic             irq_clr,
  output logic [31:0]      desc_cur_addr,
  output logic [31:0]      stat_cur_addr
);
  localparam int CW = $clog2(ENTRIES + 1);

  rxr_state_e  state, state_nx;
  logic [CW-1:0] d_level, s_level;
  logic        d_avail, s_avail, take_slot, beat;
  logic [14:0] buf_idx;
  logic [15:0] buf_len, beats;
  logic        frm_q, crc_q, ovr_pend;
  logic [31:0] w0, w1;
  logic        rdata_unused;

  assign rdata_unused = mem_rdata[31];
  assign take_slot    = (state == ST_WR0);
  assign in_ready     = (state == ST_RECV) || (state == ST_DROP);
  assign beat         = in_valid && in_ready;

  rxr_credit #(.ENTRIES(ENTRIES), .ENQ_W(ENQ_W)) u_desc_credit (
    .clk(clk), .rst_n(rst_n), .reload(ring_init), .add_en(desc_enq_en),
    .add_cnt(desc_enq_cnt), .take(take_slot), .avail(d_avail), .level(d_level));

  rxr_credit #(.ENTRIES(ENTRIES), .ENQ_W(ENQ_W)) u_stat_credit (
    .clk(clk), .rst_n(rst_n), .reload(ring_init), .add_en(stat_enq_en),
    .add_cnt(stat_enq_cnt), .take(take_slot), .avail(s_avail), .level(s_level));

  rxr_ring_ptr #(.ENTRIES(ENTRIES)) u_desc_ptr (
    .clk(clk), .rst_n(rst_n), .reload(ring_init), .step(take_slot),
    .base(desc_base), .cur_addr(desc_cur_addr));

  rxr_ring_ptr #(.ENTRIES(ENTRIES)) u_stat_ptr (
    .clk(clk), .rst_n(rst_n), .reload(ring_init), .step(take_slot),
    .base(stat_base), .cur_addr(stat_cur_addr));

  rxr_status_fmt #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)) u_fmt (
    .beats(beats), .buf_idx(buf_idx), .buf_len(buf_len), .frm_err(frm_q),
    .crc_err(crc_q), .crc_incl(crc_in_len), .ovr(ovr_pend),
    .word0(w0), .word1(w1));

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (in_valid) state_nx = (d_avail && s_avail) ? ST_FETCH : ST_DROP;
      ST_FETCH: state_nx = ST_LATCH;
      ST_LATCH: state_nx = ST_RECV;
      ST_RECV:  if (beat && in_last) state_nx = ST_WR1;
      ST_DROP:  if (beat && in_last) state_nx = ST_IDLE;
      ST_WR1:   state_nx = ST_WR0;
      ST_WR0:   state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_cur_addr + 32'd4;
      end
      ST_WR1: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = stat_cur_addr + 32'd4;
        mem_wdata = w1;
      end
      ST_WR0: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = stat_cur_addr;
        mem_wdata = w0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      buf_idx  <= '0;
      buf_len  <= '0;
      beats    <= '0;
      frm_q    <= 1'b0;
      crc_q    <= 1'b0;
      ovr_pend <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_LATCH) begin
        buf_idx <= mem_rdata[30:16];
        buf_len <= mem_rdata[15:0];
        beats   <= '0;
      end
      if (state == ST_RECV && beat) begin
        if (beats != 16'hFFFF) beats <= beats + 16'd1;
        if (in_last) begin
          frm_q <= in_frame_err;
          crc_q <= in_crc_err;
        end
      end
      if (ring_init || take_slot)                  ovr_pend <= 1'b0;
      else if (state == ST_DROP && beat && in_last) ovr_pend <= 1'b1;
      if (take_slot)    rx_irq <= 1'b1;
      else if (irq_clr) rx_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk #(
  parameter int ENTRIES = 64,
  parameter int CW      = $clog2(ENTRIES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [31:0]   mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          in_ready,
  input logic          rx_irq,
  input logic [31:0]   stat_cur_addr,
  input logic [CW-1:0] d_level,
  input logic [CW-1:0] s_level,
  input logic          take_slot
);
  assert_credit_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(d_level) <= ENTRIES) && (32'(s_level) <= ENTRIES));

  assert_take_has_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_slot |-> (d_level != '0) && (s_level != '0));

  assert_word1_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == stat_cur_addr) |->
      $past(mem_we && (mem_addr == stat_cur_addr + 32'd4)));

  assert_done_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[31]);

  assert_irq_after_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(mem_we));

  assert_no_mem_while_taking_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req);
endmodule

bind rx_ring_engine rx_ring_engine_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .in_ready(in_ready),
  .rx_irq(rx_irq), .stat_cur_addr(stat_cur_addr), .d_level(d_level),
  .s_level(s_level), .take_slot(take_slot));

// File: tb/test_rx_ring_engine.sv
module test_rx_ring_engine;
  localparam int ENT = 4;
  localparam int MAXL = 40;
  localparam int MINL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring_init = 1'b0;
  logic [31:0] desc_base = 32'h0, stat_base = 32'h100;
  logic desc_enq_en = 1'b0, stat_enq_en = 1'b0;
  logic [7:0] desc_enq_cnt = '0, stat_enq_cnt = '0;
  logic crc_in_len = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_frame_err = 1'b0, in_crc_err = 1'b0;
  logic in_ready, mem_req, mem_we, rx_irq;
  logic irq_clr = 1'b0;
  logic [31:0] mem_addr, mem_wdata, desc_cur_addr, stat_cur_addr;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  rx_ring_engine #(.ENTRIES(ENT), .MAX_LEN(MAXL), .MIN_LEN(MINL), .ENQ_W(8)) i_rx_ring_engine (
    .clk(clk), .rst_n(rst_n), .ring_init(ring_init), .desc_base(desc_base),
    .stat_base(stat_base), .desc_enq_en(desc_enq_en), .desc_enq_cnt(desc_enq_cnt),
    .stat_enq_en(stat_enq_en), .stat_enq_cnt(stat_enq_cnt), .crc_in_len(crc_in_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .in_frame_err(in_frame_err), .in_crc_err(in_crc_err), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rx_irq(rx_irq), .irq_clr(irq_clr),
    .desc_cur_addr(desc_cur_addr), .stat_cur_addr(stat_cur_addr));

  logic [31:0] mem [0:127];
  int wr_count = 0;
  int order_bad = 0;

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      if (!mem_addr[2] && !mem[{mem_addr[8:3], 1'b1}][31]) order_bad++;
      mem[mem_addr[8:2]] <= mem_wdata;
      wr_count++;
    end else if (mem_req) begin
      mem_rdata <= mem[mem_addr[8:2]];
    end
  end

  int checks = 0, errors = 0;
  int slot = 0, d_cr = ENT, s_cr = ENT;
  bit ovr_exp = 1'b0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int blen_of(int s);
    return (s == 2) ? 20 : 48;
  endfunction

  function automatic logic [31:0] exp_w0(int len, bit fe, bit ce, bit ci, bit ov, int bl);
    bit runt, xtra, bad;
    logic [31:0] w;
    runt = len < MINL;
    xtra = (len > MAXL) || (len > bl);
    bad  = fe | ce | runt | xtra;
    w = 32'h8000_0000 + 32'h3000_0000;
    if (!bad) w = w + 32'h4000_0000;
    if (bad)  w = w + 32'h0020_0000;
    if (ov)   w = w + 32'h0010_0000;
    if (fe)   w = w + 32'h0008_0000;
    if (runt) w = w + 32'h0004_0000;
    if (xtra) w = w + 32'h0002_0000;
    if (ce)   w = w + 32'h0001_0000;
    if (ci)   w = w + 32'h0000_8000;
    return w;
  endfunction

  task automatic enqueue(int nd, int ns);
    desc_enq_en  = (nd != 0);
    desc_enq_cnt = 8'(nd);
    stat_enq_en  = (ns != 0);
    stat_enq_cnt = 8'(ns);
    @(negedge clk);
    desc_enq_en = 1'b0;
    stat_enq_en = 1'b0;
    d_cr = (d_cr + nd > ENT) ? ENT : d_cr + nd;
    s_cr = (s_cr + ns > ENT) ? ENT : s_cr + ns;
  endtask

  task automatic run_frame(int len, bit fe, bit ce, bit gaps);
    bit land;
    bit r;
    int wc;
    int sw;
    logic [31:0] e1, e0;
    land = (d_cr > 0) && (s_cr > 0);
    wc = wr_count;
    sw = (stat_base >> 2) + slot * 2;
    chk(!in_ready, "R11 idle ready", 32'(in_ready), 32'd0);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_last = (i == len - 1);
      in_frame_err = fe && (i == len - 1);
      in_crc_err = ce && (i == len - 1);
      do begin
        r = in_ready;
        @(negedge clk);
      end while (!r);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    in_frame_err = 1'b0;
    in_crc_err = 1'b0;
    repeat (4) @(negedge clk);
    if (land) begin
      e1 = 32'h8000_0000 | (32'(slot + 9) << 16) | 32'(len);
      e0 = exp_w0(len, fe, ce, crc_in_len, ovr_exp, blen_of(slot));
      chk(mem[sw + 1][30:16] == 15'(slot + 9), "R1 buffer index", 32'(mem[sw + 1][30:16]), 32'(slot + 9));
      chk(mem[sw + 1] == e1, "R2 word1", mem[sw + 1], e1);
      chk(mem[sw] == e0, "R3 R4 R8 word0", mem[sw], e0);
      chk(order_bad == 0, "R5 write order", 32'(order_bad), 32'd0);
      chk(rx_irq, "R10 irq set", 32'(rx_irq), 32'd1);
      slot = (slot + 1) % ENT;
      d_cr--;
      s_cr--;
      ovr_exp = 1'b0;
      chk(stat_cur_addr == stat_base + 32'(slot * 8), "R9 status addr", stat_cur_addr, stat_base + 32'(slot * 8));
      chk(desc_cur_addr == desc_base + 32'(slot * 8), "R9 desc addr", desc_cur_addr, desc_base + 32'(slot * 8));
      mem[sw] = '0;
      mem[sw + 1] = '0;
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk(!rx_irq, "R10 irq clear", 32'(rx_irq), 32'd0);
    end else begin
      chk(wr_count == wc, "R7 no write on drop", 32'(wr_count), 32'(wc));
      chk(!rx_irq, "R7 no irq on drop", 32'(rx_irq), 32'd0);
      ovr_exp = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    for (int s = 0; s < ENT; s++) begin
      mem[s * 2] = 32'h1000 + 32'(s * 32'h800);
      mem[s * 2 + 1] = (32'(s + 9) << 16) | 32'(blen_of(s));
    end
    repeat (3) @(negedge clk);
    chk(!in_ready, "R12 ready", 32'(in_ready), 32'd0);
    chk(!mem_req, "R12 mem_req", 32'(mem_req), 32'd0);
    chk(!rx_irq, "R12 irq", 32'(rx_irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(desc_cur_addr == desc_base, "R12 desc addr", desc_cur_addr, desc_base);
    chk(stat_cur_addr == stat_base, "R12 status addr", stat_cur_addr, stat_base);

    // Length sweep with mixed flags; software returns one slot per frame.
    for (int len = 1; len <= 44; len++) begin
      crc_in_len = len[0];
      run_frame(len, (len % 3) == 0, (len % 5) == 0, (len % 4) == 2);
      enqueue(1, 1);
    end

    // R6 R7 R8: exhaust both counters, then return only descriptors.
    for (int k = 0; k < ENT; k++) run_frame(12, 1'b0, 1'b0, 1'b0);
    run_frame(10, 1'b0, 1'b0, 1'b0);
    enqueue(2, 0);
    run_frame(11, 1'b0, 1'b0, 1'b1);
    enqueue(0, 10);
    run_frame(13, 1'b0, 1'b0, 1'b0);
    run_frame(14, 1'b0, 1'b1, 1'b0);
    run_frame(15, 1'b0, 1'b0, 1'b0);
    // R6 saturation: huge returns give exactly ENT more frames.
    enqueue(200, 200);
    for (int k = 0; k < ENT; k++) run_frame(9 + k, 1'b0, 1'b0, 1'b0);
    run_frame(16, 1'b1, 1'b0, 1'b0);
    run_frame(17, 1'b0, 1'b0, 1'b0);

    // R9: restart the rings at a new status base.
    stat_base = 32'h180;
    ring_init = 1'b1;
    @(negedge clk);
    ring_init = 1'b0;
    slot = 0;
    d_cr = ENT;
    s_cr = ENT;
    ovr_exp = 1'b0;
    chk(stat_cur_addr == 32'h180, "R9 reload", stat_cur_addr, 32'h180);
    chk(desc_cur_addr == desc_base, "R9 reload desc", desc_cur_addr, desc_base);
    for (int k = 0; k < ENT + 1; k++) run_frame(20 + k, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule